// File: doc/BRIEF.md
# Command Queue Status Flag Unit

This block holds two status flags for each of a set of command queues that feed a converter: an underflow flag and a fill flag. From these flags it builds the request outputs: a per-queue underflow interrupt, a per-queue fill interrupt, a per-queue fill DMA request, and one combined interrupt. The combined interrupt merges three enabled flag groups. Two of these groups are result-overflow and trigger-overrun flags, which are kept outside this block and arrive as inputs.

The underflow flag is raised when a triggered queue runs dry. The fill flag reports that a queue has room. A per-queue select bit chooses how the fill flag behaves. In interrupt mode, software acknowledges the flag with a write-one-to-clear. In DMA mode, the flag drops by itself once the queue is full again, and a software clear is a forbidden access. Such a write is ignored and latches a sticky error bit. Software clears use a write strobe and two write-one-to-clear bit vectors.

The block carries no data stream. Every pin is a plain level control or status signal, so no valid/ready handshake or back-pressure applies. The per-queue indications are sampled every cycle. All flags are registered, and the request outputs follow the flags combinationally.

Top module: `cq_status_unit`

## Requirements
- R1: While reset is asserted, the following outputs read zero: every flag, every request output and the error bit.
- R2: The underflow flag of queue i sets on the clock after a cycle in which q_trig[i] is 1, q_empty[i] is 1 and q_empty[i] was 0 in the previous cycle. Reset counts as a previous state of empty. An untriggered queue never sets the flag. A queue that stays empty does not set it again.
- R3: With wr_en at 1, a 1 in bit i of wr_unf_clr clears underflow flag i on the next clock. A 0 bit leaves that flag unchanged.
- R4: unf_irq[i] is 1 exactly when underflow flag i and unf_ie[i] are both 1.
- R5: The fill flag of queue i sets on the clock after any cycle in which q_full[i] is 0.
- R6: In interrupt mode (fill_dma_sel[i] = 0), a full queue keeps its fill flag. The flag is cleared only by wr_en with bit i of wr_fill_clr at 1.
- R7: In DMA mode (fill_dma_sel[i] = 1), the fill flag clears on the clock after a cycle in which q_full[i] is 1.
- R8: In DMA mode, a write of 1 to bit i of wr_fill_clr is ignored. It sets wr_err on the next clock, and wr_err stays 1 until reset.
- R9: When fill flag i and fill_ie[i] are both 1, the block raises fill_irq[i] if fill_dma_sel[i] is 0, or fill_dma[i] if fill_dma_sel[i] is 1. The other request stays 0, and neither is raised otherwise.
- R10: comb_irq is the OR of 18 terms: the enabled underflow flags, the enabled ovf_flag bits and the enabled tovr_flag bits over all six queues.
- R11: When a set condition (R2 or R5) and a write-one-to-clear of the same flag meet in one cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_trig | input | NQ | Queue is in the triggered state |
| q_empty | input | NQ | Queue holds no commands |
| q_full | input | NQ | Queue has no free entry |
| unf_ie | input | NQ | Underflow interrupt enable |
| fill_ie | input | NQ | Fill request enable |
| fill_dma_sel | input | NQ | Fill request kind: 0 interrupt, 1 DMA |
| ovf_flag | input | NQ | Result-overflow flags from elsewhere |
| ovf_ie | input | NQ | Result-overflow enables |
| tovr_flag | input | NQ | Trigger-overrun flags from elsewhere |
| tovr_ie | input | NQ | Trigger-overrun enables |
| wr_en | input | 1 | Status register write strobe |
| wr_unf_clr | input | NQ | Write-one-to-clear bits for underflow flags |
| wr_fill_clr | input | NQ | Write-one-to-clear bits for fill flags |
| unf_flag | output | NQ | Underflow flags |
| fill_flag | output | NQ | Fill flags |
| unf_irq | output | NQ | Per-queue underflow interrupt |
| fill_irq | output | NQ | Per-queue fill interrupt |
| fill_dma | output | NQ | Per-queue fill DMA request |
| comb_irq | output | 1 | Combined interrupt |
| wr_err | output | 1 | Sticky illegal-write indication |

## Verification
The underflow flag is exercised with three empty patterns:
- An empty edge on a triggered queue must set the flag.
- An empty edge on an untriggered queue must not set it.
- A queue that stays empty after a clear must not set it again.

These patterns separate edge detection from level detection and show whether the trigger qualifier is present.

The fill flag is run through its full-to-not-full and back-to-full cycle in both select modes, and each mode is also given a software clear. These runs show the automatic clear, the held flag and the rejected write with its sticky error.

Writes that coincide with set conditions show the precedence rule. Each source of the combined interrupt is enabled on its own, which shows that every one of its terms is present and is gated by its own enable.

// File: rtl/cq_pkg.sv
package cq_pkg;
  typedef enum logic {
    FILL_MODE_IRQ = 1'b0,
    FILL_MODE_DMA = 1'b1
  } fill_mode_e;

  localparam int CQ_NQ_DEFAULT = 6;
endpackage

// File: rtl/cq_unf_flag.sv
module cq_unf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  input  logic empty_i,
  input  logic clr_i,
  output logic flag_o
);
  logic empty_prev;
  logic set_evt;

  // empty edge while triggered; reset treats the queue as already empty
  assign set_evt = trig_i & empty_i & ~empty_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      empty_prev <= 1'b1;
      flag_o     <= 1'b0;
    end else begin
      empty_prev <= empty_i;
      if (set_evt)
        flag_o <= 1'b1;
      else if (clr_i)
        flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/cq_fill_flag.sv
module cq_fill_flag
  import cq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       full_i,
  input  fill_mode_e mode_i,
  input  logic       clr_i,
  output logic       flag_o,
  output logic       bad_wr_o
);
  // a software clear is only legal in interrupt mode
  assign bad_wr_o = clr_i & (mode_i == FILL_MODE_DMA);

  always_ff @(posedge clk) begin
    if (!rst_n)
      flag_o <= 1'b0;
    else if (!full_i)
      flag_o <= 1'b1;
    else if (mode_i == FILL_MODE_DMA)
      flag_o <= 1'b0;
    else if (clr_i)
      flag_o <= 1'b0;
  end
endmodule

// File: rtl/cq_req_merge.sv
module cq_req_merge #(
  parameter int NQ = 6
) (
  input  logic [NQ-1:0] unf_flag_i,
  input  logic [NQ-1:0] unf_ie_i,
  input  logic [NQ-1:0] fill_flag_i,
  input  logic [NQ-1:0] fill_ie_i,
  input  logic [NQ-1:0] dma_sel_i,
  input  logic [NQ-1:0] ovf_i,
  input  logic [NQ-1:0] ovf_ie_i,
  input  logic [NQ-1:0] tovr_i,
  input  logic [NQ-1:0] tovr_ie_i,
  output logic [NQ-1:0] unf_irq_o,
  output logic [NQ-1:0] fill_irq_o,
  output logic [NQ-1:0] fill_dma_o,
  output logic          comb_irq_o
);
  localparam int NTERM = 3 * NQ;

  logic [NTERM-1:0] terms;
  logic [NQ-1:0]    fill_req;

  assign unf_irq_o = unf_flag_i & unf_ie_i;
  assign fill_req  = fill_flag_i & fill_ie_i;

  genvar g;
  generate
    for (g = 0; g < NQ; g++) begin : g_route
      assign fill_irq_o[g] = fill_req[g] & ~dma_sel_i[g];
      assign fill_dma_o[g] = fill_req[g] &  dma_sel_i[g];
    end
  endgenerate

  assign terms      = {unf_irq_o, ovf_i & ovf_ie_i, tovr_i & tovr_ie_i};
  assign comb_irq_o = |terms;
endmodule

// File: rtl/cq_status_unit.sv
module cq_status_unit
  import cq_pkg::*;
#(
  parameter int NQ = cq_pkg::CQ_NQ_DEFAULT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NQ-1:0] q_trig,
  input  logic [NQ-1:0] q_empty,
  input  logic [NQ-1:0] q_full,
  input  logic [NQ-1:0] unf_ie,
  input  logic [NQ-1:0] fill_ie,
  input  logic [NQ-1:0] fill_dma_sel,
  input  logic [NQ-1:0] ovf_flag,
  input  logic [NQ-1:0] ovf_ie,
  input  logic [NQ-1:0] tovr_flag,
  input  logic [NQ-1:0] tovr_ie,
  input  logic          wr_en,
  input  logic [NQ-1:0] wr_unf_clr,
  input  logic [NQ-1:0] wr_fill_clr,
  output logic [NQ-1:0] unf_flag,
  output logic [NQ-1:0] fill_flag,
  output logic [NQ-1:0] unf_irq,
  output logic [NQ-1:0] fill_irq,
  output logic [NQ-1:0] fill_dma,
  output logic          comb_irq,
  output logic          wr_err
);
  logic [NQ-1:0] unf_clr;
  logic [NQ-1:0] fill_clr;
  logic [NQ-1:0] bad_wr;

  assign unf_clr  = {NQ{wr_en}} & wr_unf_clr;
  assign fill_clr = {NQ{wr_en}} & wr_fill_clr;

  genvar q;
  generate
    for (q = 0; q < NQ; q++) begin : g_queue
      cq_unf_flag u_unf (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_i  (q_trig[q]),
        .empty_i (q_empty[q]),
        .clr_i   (unf_clr[q]),
        .flag_o  (unf_flag[q])
      );

      cq_fill_flag u_fill (
        .clk      (clk),
        .rst_n    (rst_n),
        .full_i   (q_full[q]),
        .mode_i   (fill_mode_e'(fill_dma_sel[q])),
        .clr_i    (fill_clr[q]),
        .flag_o   (fill_flag[q]),
        .bad_wr_o (bad_wr[q])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)
      wr_err <= 1'b0;
    else if (|bad_wr)
      wr_err <= 1'b1;
  end

  cq_req_merge #(.NQ(NQ)) u_merge (
    .unf_flag_i  (unf_flag),
    .unf_ie_i    (unf_ie),
    .fill_flag_i (fill_flag),
    .fill_ie_i   (fill_ie),
    .dma_sel_i   (fill_dma_sel),
    .ovf_i       (ovf_flag),
    .ovf_ie_i    (ovf_ie),
    .tovr_i      (tovr_flag),
    .tovr_ie_i   (tovr_ie),
    .unf_irq_o   (unf_irq),
    .fill_irq_o  (fill_irq),
    .fill_dma_o  (fill_dma),
    .comb_irq_o  (comb_irq)
  );
endmodule

// File: rtl/cq_status_chk.sv
module cq_status_chk #(
  parameter int NQ = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NQ-1:0] q_trig,
  input logic [NQ-1:0] q_empty,
  input logic [NQ-1:0] q_full,
  input logic [NQ-1:0] fill_dma_sel,
  input logic          wr_en,
  input logic [NQ-1:0] wr_unf_clr,
  input logic [NQ-1:0] wr_fill_clr,
  input logic [NQ-1:0] unf_flag,
  input logic [NQ-1:0] fill_flag,
  input logic [NQ-1:0] fill_irq,
  input logic [NQ-1:0] fill_dma,
  input logic          wr_err
);
  logic [NQ-1:0] empty_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) empty_seen <= '1;
    else        empty_seen <= q_empty;
  end

  genvar i;
  generate
    for (i = 0; i < NQ; i++) begin : g_chk
      // R2
      unf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_trig[i] && q_empty[i] && !empty_seen[i]) |=> unf_flag[i]);
      // R3
      unf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_unf_clr[i] && !(q_trig[i] && q_empty[i] && !empty_seen[i])) |=> !unf_flag[i]);
      // R5
      fill_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q_full[i] |=> fill_flag[i]);
      // R6
      fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_full[i] && !fill_dma_sel[i] && !(wr_en && wr_fill_clr[i])) |=> $stable(fill_flag[i]));
      // R7
      dma_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_full[i] && fill_dma_sel[i]) |=> !fill_flag[i]);
      // R8
      bad_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_fill_clr[i] && fill_dma_sel[i]) |=> wr_err);
      // R9
      req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fill_irq[i], fill_dma[i]}));
    end
  endgenerate

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |=> wr_err);
endmodule

bind cq_status_unit cq_status_chk #(.NQ(NQ)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .q_trig       (q_trig),
  .q_empty      (q_empty),
  .q_full       (q_full),
  .fill_dma_sel (fill_dma_sel),
  .wr_en        (wr_en),
  .wr_unf_clr   (wr_unf_clr),
  .wr_fill_clr  (wr_fill_clr),
  .unf_flag     (unf_flag),
  .fill_flag    (fill_flag),
  .fill_irq     (fill_irq),
  .fill_dma     (fill_dma),
  .wr_err       (wr_err)
);

// File: tb/test_cq_status_unit.sv
`timescale 1ns/1ps
module test_cq_status_unit;
  localparam int NQ = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic [NQ-1:0] q_trig, q_empty, q_full, unf_ie, fill_ie, fill_dma_sel;
  logic [NQ-1:0] ovf_flag, ovf_ie, tovr_flag, tovr_ie, wr_unf_clr, wr_fill_clr;
  logic wr_en;
  logic [NQ-1:0] unf_flag, fill_flag, unf_irq, fill_irq, fill_dma;
  logic comb_irq, wr_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cq_status_unit #(.NQ(NQ)) i_cq_status_unit (
    .clk(clk), .rst_n(rst_n), .q_trig(q_trig), .q_empty(q_empty), .q_full(q_full),
    .unf_ie(unf_ie), .fill_ie(fill_ie), .fill_dma_sel(fill_dma_sel),
    .ovf_flag(ovf_flag), .ovf_ie(ovf_ie), .tovr_flag(tovr_flag), .tovr_ie(tovr_ie),
    .wr_en(wr_en), .wr_unf_clr(wr_unf_clr), .wr_fill_clr(wr_fill_clr),
    .unf_flag(unf_flag), .fill_flag(fill_flag), .unf_irq(unf_irq),
    .fill_irq(fill_irq), .fill_dma(fill_dma), .comb_irq(comb_irq), .wr_err(wr_err)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr_pulse(logic [NQ-1:0] u, logic [NQ-1:0] f);
    wr_en = 1'b1; wr_unf_clr = u; wr_fill_clr = f;
    tick();
    wr_en = 1'b0; wr_unf_clr = '0; wr_fill_clr = '0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; q_trig = '0; q_empty = '1; q_full = '1;
    unf_ie = '0; fill_ie = '0; fill_dma_sel = '0;
    ovf_flag = '0; ovf_ie = '0; tovr_flag = '0; tovr_ie = '0;
    wr_en = 1'b0; wr_unf_clr = '0; wr_fill_clr = '0;
    q_full[0] = 1'b0;
    repeat (3) tick();
    check("R1 unf_flag", 32'(unf_flag), 0);
    check("R1 fill_flag", 32'(fill_flag), 0);
    check("R1 requests", {fill_irq, fill_dma, unf_irq, comb_irq}, 0);
    check("R1 wr_err", 32'(wr_err), 0);
    q_full = '1;
    rst_n = 1'b1;
    tick();
    check("R2 no underflow after reset", 32'(unf_flag), 0);
  endtask

  task automatic t_unf_set();
    q_trig = 6'b000100;
    q_empty[2] = 1'b0; q_empty[3] = 1'b0;
    tick();
    q_empty[2] = 1'b1; q_empty[3] = 1'b1;
    tick();
    check("R2 triggered edge sets, untriggered not", 32'(unf_flag), 32'h04);
    q_trig[1] = 1'b1; q_empty[1] = 1'b0;
    tick();
    q_empty[1] = 1'b1;
    tick();
    check("R2 second queue sets", 32'(unf_flag), 32'h06);
  endtask

  task automatic t_unf_clear();
    wr_pulse(6'b000010, '0);
    check("R3 one bit clears, zero bits keep", 32'(unf_flag), 32'h04);
    tick(); tick();
    check("R2 steady empty does not re-set", 32'(unf_flag), 32'h04);
  endtask

  task automatic t_unf_irq();
    unf_ie = 6'b000110;
    tick();
    check("R4 unf_irq gated by enable", 32'(unf_irq), 32'h04);
    check("R10 combined from underflow", 32'(comb_irq), 1);
    unf_ie = 6'b000010;
    tick();
    check("R4 enable off drops irq", 32'(unf_irq), 0);
    check("R10 combined drops", 32'(comb_irq), 0);
    wr_pulse('1, '0);
    check("R3 clear all", 32'(unf_flag), 0);
    q_trig = '0; unf_ie = '0;
  endtask

  task automatic t_fill_irq_mode();
    fill_dma_sel = '0; fill_ie = '1;
    q_full[0] = 1'b0;
    tick();
    check("R5 fill sets when not full", 32'(fill_flag), 32'h01);
    check("R9 irq selected", 32'(fill_irq), 32'h01);
    check("R9 no dma in irq mode", 32'(fill_dma), 0);
    q_full[0] = 1'b1;
    tick(); tick();
    check("R6 full keeps flag in irq mode", 32'(fill_flag), 32'h01);
    wr_pulse('0, 6'b000001);
    check("R6 write-one clears", 32'(fill_flag), 0);
    check("R8 legal write no error", 32'(wr_err), 0);
  endtask

  task automatic t_fill_dma_mode();
    fill_dma_sel = 6'b000010; fill_ie = 6'b000010;
    q_full[1] = 1'b0;
    tick();
    check("R5 fill sets dma queue", 32'(fill_flag), 32'h02);
    check("R9 dma selected", 32'(fill_dma), 32'h02);
    check("R9 no irq in dma mode", 32'(fill_irq), 0);
    fill_ie = '0;
    tick();
    check("R9 enable off no request", {fill_irq, fill_dma}, 0);
    q_full[1] = 1'b1;
    tick();
    check("R7 auto clear on full", 32'(fill_flag), 0);
  endtask

  task automatic t_illegal_write();
    q_full[1] = 1'b0;
    tick();
    q_full[1] = 1'b1;
    wr_pulse('0, 6'b000010);
    check("R8 error set", 32'(wr_err), 1);
    check("R8 flag state unchanged by write", 32'(fill_flag), 0);
    repeat (3) tick();
    check("R8 error sticky", 32'(wr_err), 1);
    fill_dma_sel = '0;
  endtask

  task automatic t_combined();
    ovf_flag = 6'b010000;
    tick();
    check("R10 disabled overflow", 32'(comb_irq), 0);
    ovf_ie = 6'b010000;
    tick();
    check("R10 enabled overflow", 32'(comb_irq), 1);
    ovf_flag = '0; tovr_flag = 6'b100000;
    tick();
    check("R10 disabled overrun", 32'(comb_irq), 0);
    tovr_ie = 6'b100000;
    tick();
    check("R10 enabled overrun", 32'(comb_irq), 1);
    tovr_flag = '0;
    tick();
    check("R10 all clear", 32'(comb_irq), 0);
  endtask

  task automatic t_set_wins();
    q_trig[5] = 1'b1; q_empty[5] = 1'b0;
    tick();
    q_empty[5] = 1'b1;
    wr_pulse(6'b100000, '0);
    check("R11 underflow set beats clear", 32'(unf_flag), 32'h20);
    q_full[3] = 1'b0;
    wr_pulse('0, 6'b001000);
    check("R11 fill set beats clear", 32'(fill_flag[3]), 1);
  endtask

  initial begin
    t_reset();
    t_unf_set();
    t_unf_clear();
    t_unf_irq();
    t_fill_irq_mode();
    t_fill_dma_mode();
    t_illegal_write();
    t_combined();
    t_set_wins();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule